// File: doc/BRIEF.md
# Single-Wire Game Controller Host Interface

This block is the host end of a challenge/response link to a game controller over one shared open-drain data wire. A one-cycle `start` pulse loads an 8-bit command code, for example 0x01 to read the buttons, 0x00 for status or 0xFF to reset the controller. The block then sends that code followed by a stop bit of value 1. Each bit on the wire is three equal sub-bits of `SUB_CYC` clock cycles: low, then the data value, then high. At 27 MHz, `SUB_CYC` = 27 gives 1 µs sub-bits.

After the stop bit the block releases the wire. The pull-up then holds the wire high, and the block listens for the reply. The wire input crosses into the local clock through a two-flop synchronizer. A high-to-low transition on the synchronized level marks the start of each reply bit. The block waits `SAMPLE_CYC` cycles (54, which is 2 µs) and then takes the wire level as that bit's value.

A reply is 32 data bits followed by a stop bit. When the stop bit has been sampled, the 32-bit word is presented in parallel together with a one-cycle valid strobe. If no falling edge arrives within `TMO_CYC` cycles (270, which is 10 µs), the block raises a one-cycle timeout flag and returns to idle. The system above can then re-issue the request or send a controller reset.

Top module: `swc_host`

## Requirements
- R1: While reset is asserted and after it is released, `line_oe`, `busy`, `rx_valid` and `rx_timeout` are 0 and `rx_word` is 0.
- R2: A `start` seen while idle is accepted on that clock edge. From the next cycle `line_oe` is 1 for 9 bits × 3 × `SUB_CYC` cycles. The 9 bits are the command MSB first, then a 1. Each bit drives `line_o` 0 for `SUB_CYC` cycles, then the bit value for `SUB_CYC` cycles, then 1 for `SUB_CYC` cycles.
- R3: Directly after the last high sub-bit of the stop bit, `line_oe` drops to 0. It stays 0 until the next accepted command.
- R4: A `start` pulse while `busy` is 1 is ignored. The wire sequence in progress continues unchanged.
- R5: Every reply bit takes the wire level seen `SAMPLE_CYC` cycles after the falling edge at `line_i`.
- R6: After 33 reply bits, `rx_valid` pulses for one cycle. In that same cycle `rx_word` holds the first 32 bits, with the first received bit in bit 31. The stop bit is discarded. `rx_word` keeps its value until the next valid reply.
- R7: Falling edges that arrive while a sample is pending are ignored.
- R8: If no falling edge arrives within `TMO_CYC` cycles of the end of transmit or of the last sample, `rx_timeout` pulses for one cycle. In that cycle `busy` is 0, `rx_valid` stays 0 and `rx_word` is unchanged.
- R9: After a timeout, a new command is accepted and completes normally.
- R10: `busy` is 1 from the cycle after `start` is accepted up to, but not including, the cycle of `rx_valid` or `rx_timeout`.
- R11: Falling edges on `line_i` while idle produce no `rx_valid`, no `rx_timeout` and no `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock (27 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to send `cmd` |
| cmd | input | 8 | Command code to send |
| line_i | input | 1 | Level seen on the shared data wire |
| line_o | output | 1 | Value driven onto the wire while `line_oe` is 1 |
| line_oe | output | 1 | 1 while the host drives the wire, 0 when released to the pull-up |
| rx_word | output | 32 | Last complete reply word |
| rx_valid | output | 1 | One-cycle strobe: `rx_word` updated |
| rx_timeout | output | 1 | One-cycle strobe: reply stalled, block back to idle |
| busy | output | 1 | Transaction in progress |

## Verification
The assertions assume that the controller drives the wire only while the host has released it. They also assume that reply falling edges come less than `TMO_CYC` cycles apart, that the wire is steady around each sample instant, and that `start` is a single-cycle pulse. The bench's controller model waits for `line_oe` to fall before it answers. It starts its first bit 40 cycles after the release and spaces bits 108 cycles apart. It holds each data level from cycle 27 to cycle 80 after the bit's falling edge, so the sample at cycle 54 lands well inside that level. The glitches it injects stay inside the pending-sample window, and its stalled replies simply stop driving.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {SB_START = 2'd0, SB_DATA = 2'd1, SB_STOP = 2'd2} subbit_t;
  typedef enum logic [1:0] {RX_IDLE = 2'd0, RX_HUNT = 2'd1, RX_WAIT = 2'd2} rx_state_t;
endpackage

// File: rtl/swc_line_sync.sv
module swc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pad_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/swc_tx.sv
module swc_tx
  import swc_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int SUB_CYC = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CMD_W-1:0] cmd,
  output logic             line_o,
  output logic             line_oe,
  output logic             done
);
  localparam int FRAME_BITS = CMD_W + 1;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int CYC_W      = $clog2(SUB_CYC);

  logic                  active_q, active_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [CYC_W-1:0]      cyc_q, cyc_d;
  subbit_t               sub_q, sub_d;
  logic                  last_cyc, last_bit;

  assign last_cyc = (cyc_q == CYC_W'(SUB_CYC - 1));
  assign last_bit = (bit_q == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    active_d = active_q;
    sh_d     = sh_q;
    bit_d    = bit_q;
    cyc_d    = cyc_q;
    sub_d    = sub_q;
    if (!active_q) begin
      if (go) begin
        active_d = 1'b1;
        sh_d     = {cmd, 1'b1};
        bit_d    = '0;
        cyc_d    = '0;
        sub_d    = SB_START;
      end
    end else if (last_cyc) begin
      cyc_d = '0;
      case (sub_q)
        SB_START: sub_d = SB_DATA;
        SB_DATA:  sub_d = SB_STOP;
        default: begin
          if (last_bit) begin
            active_d = 1'b0;
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
            sub_d = SB_START;
          end
        end
      endcase
    end else begin
      cyc_d = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
      cyc_q    <= '0;
      sub_q    <= SB_START;
    end else begin
      active_q <= active_d;
      sh_q     <= sh_d;
      bit_q    <= bit_d;
      cyc_q    <= cyc_d;
      sub_q    <= sub_d;
    end
  end

  assign line_oe = active_q;
  assign line_o  = !active_q           ? 1'b1 :
                   (sub_q == SB_START) ? 1'b0 :
                   (sub_q == SB_DATA)  ? sh_q[FRAME_BITS-1] : 1'b1;
  assign done    = active_q && (sub_q == SB_STOP) && last_cyc && last_bit;

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !line_o);
  // R3
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> $past(line_o));
endmodule

// File: rtl/swc_rx.sv
module swc_rx
  import swc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SAMPLE_CYC = 54,
  parameter int TMO_CYC    = 270
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              fall,
  input  logic              lvl,
  output logic [DATA_W-1:0] word,
  output logic              valid,
  output logic              timeout,
  output logic              busy
);
  localparam int FRAME_BITS = DATA_W + 1;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int CNT_MAX    = (SAMPLE_CYC > TMO_CYC) ? SAMPLE_CYC : TMO_CYC;
  localparam int CNT_W      = $clog2(CNT_MAX);

  rx_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d, word_q, word_d;
  logic              valid_q, valid_d, tmo_q, tmo_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    word_d  = word_q;
    valid_d = 1'b0;
    tmo_d   = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (arm) begin
          st_d  = RX_HUNT;
          cnt_d = '0;
          idx_d = '0;
        end
      end
      RX_HUNT: begin
        if (fall) begin
          st_d  = RX_WAIT;
          cnt_d = '0;
        end else if (cnt_q == CNT_W'(TMO_CYC - 1)) begin
          st_d  = RX_IDLE;
          tmo_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_WAIT: begin
        if (cnt_q == CNT_W'(SAMPLE_CYC - 1)) begin
          cnt_d = '0;
          if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
            st_d    = RX_IDLE;
            valid_d = 1'b1;
            word_d  = sh_q;
          end else begin
            sh_d  = {sh_q[DATA_W-2:0], lvl};
            idx_d = idx_q + 1'b1;
            st_d  = RX_HUNT;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      valid_q <= valid_d;
      tmo_q   <= tmo_d;
    end
  end

  assign word    = word_q;
  assign valid   = valid_q;
  assign timeout = tmo_q;
  assign busy    = (st_q != RX_IDLE);

  // R6
  valid_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(st_q) == RX_WAIT);
  // R8
  tmo_from_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> ($past(st_q) == RX_HUNT) && !$past(fall));
  // R7
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_WAIT) && fall && (cnt_q != CNT_W'(SAMPLE_CYC - 1)) |=> st_q == RX_WAIT);
endmodule

// File: rtl/swc_host.sv
module swc_host #(
  parameter int CMD_W       = 8,
  parameter int DATA_W      = 32,
  parameter int SUB_CYC     = 27,
  parameter int SAMPLE_CYC  = 54,
  parameter int TMO_CYC     = 270,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              line_i,
  output logic              line_o,
  output logic              line_oe,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_timeout,
  output logic              busy
);
  logic [1:0] rst_q;
  logic       srst_n, go, tx_done, lvl, fall, rx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  assign busy = line_oe | rx_busy;
  assign go   = start & ~busy;

  swc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .pad_i(line_i), .lvl_o(lvl), .fall_o(fall));

  swc_tx #(.CMD_W(CMD_W), .SUB_CYC(SUB_CYC)) u_tx (
    .clk(clk), .rst_n(srst_n), .go(go), .cmd(cmd),
    .line_o(line_o), .line_oe(line_oe), .done(tx_done));

  swc_rx #(.DATA_W(DATA_W), .SAMPLE_CYC(SAMPLE_CYC), .TMO_CYC(TMO_CYC)) u_rx (
    .clk(clk), .rst_n(srst_n), .arm(tx_done), .fall(fall), .lvl(lvl),
    .word(rx_word), .valid(rx_valid), .timeout(rx_timeout), .busy(rx_busy));

  // R10
  busy_before_end_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_valid || rx_timeout) |-> $past(busy) && !busy);
  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!srst_n)
    line_oe && start |=> line_oe || rx_busy);
endmodule

// File: tb/sim_swc_host.sv
module sim_swc_host;
  localparam int SUB = 27, SAMP = 54, TMO = 270;
  localparam int FRAME_CYC = 9 * 3 * SUB;
  localparam int DELAY = 40, BIT_CYC = 108;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ctrl_low = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic line_o, line_oe, rx_valid, rx_timeout, busy, line;
  logic [31:0] rx_word;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int tx_s0 = -100000, exp_valid = -1, exp_tmo = -1, busy_s = 0, busy_e = 0;
  logic [7:0] tx_cmd = 8'h00;
  logic [31:0] exp_word = 32'h0;
  bit chk_on = 1'b0;
  string phase = "";

  always #2 clk = ~clk;
  assign line = line_oe ? line_o : ~ctrl_low;

  swc_host u0 (.clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .line_i(line),
    .line_o(line_o), .line_oe(line_oe), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_timeout(rx_timeout), .busy(busy));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // per-cycle reference model
  always @(negedge clk) if (chk_on) begin
    automatic int n = cyc - tx_s0;
    automatic bit e_oe = (n >= 0) && (n < FRAME_CYC);
    automatic int b = n / (3 * SUB);
    automatic int s = (n / SUB) % 3;
    automatic logic fb = (b < 8) ? tx_cmd[7 - b] : 1'b1;
    automatic logic e_o = (s == 0) ? 1'b0 : (s == 1) ? fb : 1'b1;
    chk(e_oe ? {"R2 oe ", phase} : {"R3 oe ", phase}, 32'(line_oe), 32'(e_oe));
    if (e_oe) chk({"R2 data ", phase}, 32'(line_o), 32'(e_o));
    chk({"R10 busy ", phase}, 32'(busy), 32'((cyc >= busy_s) && (cyc < busy_e)));
    chk({"R6 valid ", phase}, 32'(rx_valid), 32'(cyc == exp_valid));
    chk({"R8 timeout ", phase}, 32'(rx_timeout), 32'(cyc == exp_tmo));
    if (cyc == exp_valid) chk({"R6 word R5 ", phase}, rx_word, exp_word);
    if (cyc == exp_tmo)   chk({"R8 word hold ", phase}, rx_word, exp_word);
  end

  task automatic issue(input logic [7:0] c);
    @(negedge clk);
    start = 1'b1; cmd = c;
    tx_cmd = c; tx_s0 = cyc + 1; busy_s = cyc + 1;
    exp_valid = -1; exp_tmo = cyc + 1 + FRAME_CYC + TMO; busy_e = exp_tmo;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic reply(input logic [31:0] w, input int nbits, input bit glitch);
    automatic logic [32:0] fr = {w, 1'b1};
    while (cyc < tx_s0 + FRAME_CYC + DELAY) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      automatic logic d = fr[32 - i];
      automatic int smp = cyc + 3 + SAMP;
      if (i == 32) begin
        exp_word = w; exp_valid = smp; exp_tmo = -1; busy_e = smp;
      end else begin
        exp_tmo = smp + TMO; busy_e = exp_tmo;
      end
      for (int k = 0; k < BIT_CYC; k++) begin
        ctrl_low = (k < SUB) || ((k < 3 * SUB) && !d) ||
                   (glitch && d && (k >= 35) && (k < 38));
        @(negedge clk);
      end
    end
    ctrl_low = 1'b0;
  endtask

  task automatic wait_end();
    while (cyc <= busy_e + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: outputs during reset
    chk("R1 oe in reset", 32'(line_oe), 32'h0);
    chk("R1 busy in reset", 32'(busy), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe", 32'(line_oe), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 valid", 32'(rx_valid), 32'h0);
    chk("R1 timeout", 32'(rx_timeout), 32'h0);
    chk("R1 word", rx_word, 32'h0);
    chk_on = 1'b1;

    phase = "R2";
    issue(8'h01);
    reply(32'hA5C3_0F81, 33, 1'b0);
    wait_end();

    phase = "R4 R7";
    issue(8'h00);
    repeat (300) @(negedge clk);
    start = 1'b1; cmd = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    reply(32'h1234_5678, 33, 1'b1);
    wait_end();

    phase = "R8";
    issue(8'hFF);
    wait_end();

    phase = "R9";
    issue(8'h01);
    reply(32'hDEAD_BEEF, 10, 1'b0);
    wait_end();
    issue(8'h01);
    reply(32'hFFFF_0000, 33, 1'b0);
    wait_end();

    phase = "R11";
    for (int p = 0; p < 3; p++) begin
      ctrl_low = 1'b1;
      repeat (20) @(negedge clk);
      ctrl_low = 1'b0;
      repeat (100) @(negedge clk);
    end
    repeat (TMO + 20) @(negedge clk);
    chk("R11 word after idle edges", rx_word, 32'hFFFF_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule